// File: doc/BRIEF.md
# Per-Line Trigger Interrupt Controller

This block takes up to 32 external interrupt sources. Each source drives its own output interrupt line, one to one. Sources are never merged, prioritised or vectored. Software chooses, for each line, whether the source is edge or level sensitive and which polarity is active. A detected event is held in a per-line status bit. An enable mask gates that bit onto the output line.

Software programs the block through a small 32-bit register bus with an address, a write strobe, a read strobe, write data and registered read data. The register window is 0x20 bytes. It holds an enable word, a mode word (1 = edge, 0 = level), a polarity word (1 = rising or high, 0 = falling or low) and a status word. Software acknowledges edge events by writing ones to the status word.

The expected bring-up sequence is to write 0 to the enable, mode and polarity words and all ones to the status word. After that, every line is masked, set to active-low level, and has no pending event.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, enable, mode, polarity and status all read 0 and every output is low. This assumes all sources are idle high.
- R2: The registers sit at fixed byte offsets: enable at 0x00, mode at 0x04, polarity at 0x08 and status at 0x0C. Read data appears on the clock edge after a read strobe. Enable, mode and polarity read back the value last written. Offsets 0x10 to 0x1C read as zero.
- R3: With mode=1 and polarity=1, a rising edge on a source sets its status bit. A falling edge on that source does not.
- R4: With mode=1 and polarity=0, a falling edge sets the status bit. A rising edge does not.
- R5: With mode=0 and polarity=1, the status bit follows the source while the source is high. Writing 1 to the status bit does not clear it during that time. It drops once the source goes low.
- R6: With mode=0 and polarity=0, the status bit and the enabled output are active while the source is low. They go inactive when the source is high.
- R7: An output is high only when the line's enable bit is 1. An edge latched while the line is masked appears on the output once the line is enabled.
- R8: For an edge line, writing 1 to its status bit clears the bit. Writing 0 leaves it set. With no clear, the bit stays set.
- R9: If a new edge on a line is detected in the same cycle as a clear write to that line, the status bit stays set.
- R10: Each output depends only on its own source. An event on one line leaves the other outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Asynchronous interrupt sources |
| irq_out | output | 32 | Per-line interrupt outputs |

## Verification
Each of the four trigger encodings is exercised with both directions of source transition. This shows that edge lines respond to only one transition and that level lines track the source. Status is probed with a zero write, a one write, and a one write that lands in the same cycle as a fresh edge, to separate acknowledge from set priority. A masked edge followed by a late enable, and a pulse on one line of an enabled pair, separate the gating from any leakage between lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W    = 32;
  localparam int WORD_LSB = 2;
  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_MODE = 3'd1,
    SEL_POL  = 3'd2,
    SEL_STAT = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  // Reset to the idle-high level so active-low and falling lines see no event
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  logic [N-1:0] prev;
  logic [N-1:0] active;
  logic [N-1:0] edge_hit;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      active[i]   = pol[i] ? sig[i] : ~sig[i];
      edge_hit[i] = pol[i] ? (sig[i] & ~prev[i]) : (~sig[i] & prev[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i]   <= 1'b1;
        status[i] <= 1'b0;
      end else begin
        prev[i] <= sig[i];
        if (mode[i])
          status[i] <= edge_hit[i] | (status[i] & ~clr[i]);
        else
          status[i] <= active[i];
      end
    end
  end

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode & status & ~clr) != '0) |=>
      ((status & $past(mode & status & ~clr)) == $past(mode & status & ~clr)));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode & edge_hit & clr) != '0) |=>
      ((status & $past(mode & edge_hit & clr)) == $past(mode & edge_hit & clr)));
  // R5
  level_track_chk: assert property (@(posedge clk) disable iff (rst)
    ((~mode & active) != '0) |=>
      ((status & $past(~mode & active)) == $past(~mode & active)));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N-1:0]      status,
  output logic [REG_W-1:0]  rdata,
  output logic [N-1:0]      en,
  output logic [N-1:0]      mode,
  output logic [N-1:0]      pol,
  output logic [N-1:0]      clr
);
  localparam int WSEL_W = ADDR_W - WORD_LSB;

  logic [WSEL_W-1:0] wsel;
  logic [REG_W-1:0]  rd_mux;

  assign wsel = addr[ADDR_W-1:WORD_LSB];

  always_comb begin
    clr = '0;
    if (wr && wsel == WSEL_W'(SEL_STAT))
      clr = wdata[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      mode <= '0;
      pol  <= '0;
    end else if (wr) begin
      if (wsel == WSEL_W'(SEL_EN))   en   <= wdata[N-1:0];
      if (wsel == WSEL_W'(SEL_MODE)) mode <= wdata[N-1:0];
      if (wsel == WSEL_W'(SEL_POL))  pol  <= wdata[N-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (wsel == WSEL_W'(SEL_EN))   rd_mux[N-1:0] = en;
    else if (wsel == WSEL_W'(SEL_MODE)) rd_mux[N-1:0] = mode;
    else if (wsel == WSEL_W'(SEL_POL))  rd_mux[N-1:0] = pol;
    else if (wsel == WSEL_W'(SEL_STAT)) rd_mux[N-1:0] = status;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R1
  cfg_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (en == '0 && mode == '0 && pol == '0));
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && wsel > WSEL_W'(SEL_STAT)) |=> (rdata == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N-1:0]      src_in,
  output logic [N-1:0]      irq_out
);
  logic [N-1:0] sig_s, en, mode, pol, clr, status;

  irqc_sync #(.W(N)) u_sync (
    .clk(clk), .rst(rst), .d(src_in), .q(sig_s)
  );

  irqc_detect #(.N(N)) u_detect (
    .clk(clk), .rst(rst), .sig(sig_s), .mode(mode), .pol(pol),
    .clr(clr), .status(status)
  );

  irqc_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .status(status), .rdata(bus_rdata),
    .en(en), .mode(mode), .pol(pol), .clr(clr)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= status & en;
  end

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~$past(en)) == '0));
endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src = '1;
  logic [31:0] irq;
  int errors = 0, checks = 0;

  localparam logic [4:0] A_EN = 5'h00, A_MODE = 5'h04, A_POL = 5'h08, A_STAT = 5'h0C;

  always #2.5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src), .irq_out(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic setup(input logic [31:0] m, input logic [31:0] p, input logic [31:0] e);
    bwr(A_EN, 32'h0); bwr(A_MODE, m); bwr(A_POL, p);
    wcyc(5); bwr(A_STAT, 32'hFFFF_FFFF); bwr(A_EN, e);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    brd(A_EN, v);   chk("R1 enable", v, 0);
    brd(A_MODE, v); chk("R1 mode", v, 0);
    brd(A_POL, v);  chk("R1 polarity", v, 0);
    brd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq_out", irq, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    bwr(A_EN, 32'hA5A5_0F0F); brd(A_EN, v); chk("R2 enable rw", v, 32'hA5A5_0F0F);
    bwr(A_EN, 32'h0);
    bwr(A_MODE, 32'h1234_5678); brd(A_MODE, v); chk("R2 mode rw", v, 32'h1234_5678);
    bwr(A_POL, 32'hCAFE_0001); brd(A_POL, v); chk("R2 polarity rw", v, 32'hCAFE_0001);
    brd(5'h10, v); chk("R2 unmapped 0x10", v, 0);
    brd(5'h1C, v); chk("R2 unmapped 0x1C", v, 0);
    setup(0, 0, 0);
  endtask

  task automatic t_rising;
    logic [31:0] v;
    setup(32'h8, 32'h8, 32'h8);
    src[3] = 1'b0; wcyc(6);
    brd(A_STAT, v); chk("R3 falling ignored", v & 32'h8, 0);
    src[3] = 1'b1; wcyc(6);
    chk("R3 rising irq", irq & 32'h8, 32'h8);
    brd(A_STAT, v); chk("R3 rising status", v & 32'h8, 32'h8);
  endtask

  task automatic t_falling;
    logic [31:0] v;
    setup(32'h10, 32'h0, 32'h10);
    src[4] = 1'b0; wcyc(6);
    chk("R4 falling irq", irq & 32'h10, 32'h10);
    bwr(A_STAT, 32'h10); src[4] = 1'b1; wcyc(6);
    brd(A_STAT, v); chk("R4 rising ignored", v & 32'h10, 0);
  endtask

  task automatic t_level_high;
    logic [31:0] v;
    src[5] = 1'b0;
    setup(32'h0, 32'h20, 32'h20);
    chk("R5 idle low", irq & 32'h20, 0);
    src[5] = 1'b1; wcyc(6);
    chk("R5 high irq", irq & 32'h20, 32'h20);
    bwr(A_STAT, 32'h20); wcyc(1);
    brd(A_STAT, v); chk("R5 clear ignored while active", v & 32'h20, 32'h20);
    src[5] = 1'b0; wcyc(6);
    chk("R5 drops when low", irq & 32'h20, 0);
    src[5] = 1'b1;
    setup(0, 0, 0);
  endtask

  task automatic t_level_low;
    setup(32'h0, 32'h0, 32'h40);
    chk("R6 idle high inactive", irq & 32'h40, 0);
    src[6] = 1'b0; wcyc(6);
    chk("R6 low irq", irq & 32'h40, 32'h40);
    src[6] = 1'b1; wcyc(6);
    chk("R6 released", irq & 32'h40, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    setup(32'h100, 32'h100, 32'h0);
    src[8] = 1'b0; wcyc(2); src[8] = 1'b1; wcyc(6);
    chk("R7 masked irq low", irq & 32'h100, 0);
    brd(A_STAT, v); chk("R7 latched while masked", v & 32'h100, 32'h100);
    bwr(A_EN, 32'h100); wcyc(2);
    chk("R7 appears on enable", irq & 32'h100, 32'h100);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    setup(32'h200, 32'h0, 32'h200);
    src[9] = 1'b0; wcyc(6); src[9] = 1'b1; wcyc(4);
    bwr(A_STAT, 32'h0); wcyc(2);
    brd(A_STAT, v); chk("R8 zero write keeps", v & 32'h200, 32'h200);
    bwr(A_STAT, 32'h200); wcyc(2);
    brd(A_STAT, v); chk("R8 one write clears", v & 32'h200, 0);
    chk("R8 irq cleared", irq & 32'h200, 0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    setup(32'h400, 32'h400, 32'h400);
    src[10] = 1'b0; wcyc(2); src[10] = 1'b1; wcyc(6);
    src[10] = 1'b0; wcyc(6);
    // new rising edge: s2 updates at 2nd edge, status sets at 3rd edge
    @(negedge clk); src[10] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = A_STAT; wdata = 32'h400; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    wcyc(2);
    brd(A_STAT, v); chk("R9 set wins over clear", v & 32'h400, 32'h400);
  endtask

  task automatic t_isolation;
    setup(32'h3000, 32'h3000, 32'h3000);
    src[12] = 1'b0; wcyc(2); src[12] = 1'b1; wcyc(6);
    chk("R10 only own line", irq, 32'h1000);
    setup(0, 0, 0);
    chk("R10 all low after clear", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    wcyc(4);
    rst = 1'b0;
    wcyc(3);
    t_reset();
    t_regs();
    t_rising();
    t_falling();
    t_level_high();
    t_level_low();
    t_mask();
    t_w1c();
    t_collision();
    t_isolation();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule